// File: doc/BRIEF.md
# Two-Stage Switch Allocator with Registered Crossbar

This block performs switch allocation and switch traversal for a router with N ports, each port carrying V virtual channels. Each input virtual channel offers its head flit along with an already allocated output port and output VC. In the first cycle a separable allocator chooses winners. It runs a round-robin choice among the VCs of each input, then a round-robin choice among the inputs that want each output. Each winner gets a dequeue pulse. The winning flit of each input is captured in a per-input stage register, and the per-output crossbar selects are captured beside it.

In the following cycle the captured flits cross the crossbar to their output links. The low VC-identifier field of each flit is overwritten with its allocated output VC, and one credit is taken from that output VC. The stage registers have no flow control. A request is raised only when the VC holds a valid flit, its output VC is locked, and that output VC has a credit not already claimed by a flit in flight. A granted flit therefore never waits. Credits returned from downstream are folded into the same counters.

Top module: `sa_xbar_pipe`

## Requirements
- R1: After reset, out_valid and deq are all 0. Every output VC then holds DEPTH credits, so exactly DEPTH flits can be sent to one output VC before any credit is returned.
- R2: An input VC is dequeued only when flit_valid and out_vc_lock are both 1 for it. While out_vc_lock is 0 its flit is never dequeued or delivered.
- R3: In one cycle at most one VC of an input is dequeued, and at most one flit leaves each output.
- R4: A flit dequeued in cycle k appears in cycle k+1 on the out_valid and out_data of the output named by its out_port, and it is never held back. The number of valid outputs in cycle k+1 equals the number of dequeues in cycle k.
- R5: The delivered flit equals the input flit except that bits [VC_W-1:0] (the VC-identifier field) carry the allocated out_vc.
- R6: Among the requesting VCs of one input, grants rotate round-robin starting from VC 0 after reset. With VCs 0 and 1 of an input requesting continuously, the grants go 0,1,0,1.
- R7: Among the inputs competing for one output, grants rotate round-robin starting from input 0 after reset. With inputs 0 and 1 competing continuously, the output order is input 0, input 1, input 0, and so on. An arbiter's pointer moves only when its grant is accepted.
- R8: No flit is sent to an output VC whose credit count is 0, counting a flit already in flight as having used its credit. Credit slot j*V+c (credit_in bit) belongs to output j, VC c.
- R9: A credit return and a consumption on the same output VC in the same cycle leave its count unchanged. The number of flits delivered to one output VC is DEPTH plus the credits returned to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flit_valid | input | N_PORTS*N_VC | Head flit present, bit i*N_VC+v for input i, VC v |
| flit_data | input | N_PORTS*N_VC*DATA_W | Head flit of each input VC |
| out_port | input | N_PORTS*N_VC*PW | Allocated output port of each input VC |
| out_vc | input | N_PORTS*N_VC*VW | Allocated output VC of each input VC |
| out_vc_lock | input | N_PORTS*N_VC | Output VC allocation held by this input VC |
| deq | output | N_PORTS*N_VC | One-cycle dequeue pulse to the input VC buffer |
| out_valid | output | N_PORTS | Flit present on the output link |
| out_data | output | N_PORTS*DATA_W | Flit on the output link with VC field rewritten |
| credit_in | input | N_PORTS*N_VC | Credit return per output VC, bit j*N_VC+c |

## Verification
A stale or misadvanced arbiter pointer shows within a few grants as a broken alternation in the order of arrivals at a contested output, or in the order of dequeues at an input. A credit counter that drifts shows as one flit too many or too few delivered to an exhausted output VC. A lost stage-register load shows in the very next cycle, as a dequeue with no matching output or an output carrying the wrong source, port or VC field.

// File: rtl/sa_pkg.sv
// Shared helpers for the switch allocation pipeline.
// Assumes: callers pass positive counts.
package sa_pkg;
    // Index width for a count, never less than one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/sa_rr_arb.sv
// Round-robin arbiter: grants the first requester at or after the pointer.
// Assumes: accept is only meaningful when a grant is issued; the pointer moves
// to one past the winner only on accept, and resets to index 0.
module sa_rr_arb #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] req,
    input  logic             accept,
    output logic [WIDTH-1:0] gnt
);
    localparam int IW = sa_pkg::idx_w(WIDTH);

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;

    // Search from the pointer, wrapping once around.
    always_comb begin : pick
        int  idx;
        logic found;
        gnt   = '0;
        win   = ptr;
        found = 1'b0;
        for (int k = 0; k < WIDTH; k++) begin
            idx = int'(ptr) + k;
            if (idx >= WIDTH) idx = idx - WIDTH;
            if (!found && req[idx]) begin
                found    = 1'b1;
                gnt[idx] = 1'b1;
                win      = IW'(idx);
            end
        end
    end

    // Advance the pointer past an accepted winner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (accept && (|gnt)) begin
            ptr <= (int'(win) == WIDTH - 1) ? '0 : win + 1'b1;
        end
    end
endmodule

// File: rtl/sa_sep_alloc.sv
// Separable input-first switch allocator.
// Stage one picks one VC per input; stage two picks one input per output.
// Assumes: port_of holds valid port numbers for requesting VCs.
module sa_sep_alloc #(
    parameter int N_PORTS = 4,
    parameter int N_VC    = 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [N_PORTS*N_VC-1:0]              req,
    input  logic [N_PORTS*N_VC*sa_pkg::idx_w(N_PORTS)-1:0] port_of,
    output logic [N_PORTS*N_VC-1:0]              deq,
    output logic [N_PORTS-1:0]                   in_acc,
    output logic [N_PORTS*N_PORTS-1:0]           out_gnt,
    output logic [N_PORTS-1:0]                   out_any
);
    localparam int PW = sa_pkg::idx_w(N_PORTS);

    logic [N_PORTS*N_VC-1:0]    vc_gnt;
    logic [N_PORTS-1:0]         in_any;
    logic [PW-1:0]              win_port [N_PORTS];
    logic [N_PORTS*N_PORTS-1:0] out_req;

    genvar gi, gj;
    generate
        for (gi = 0; gi < N_PORTS; gi++) begin : g_in
            sa_rr_arb #(.WIDTH(N_VC)) u_vc_arb (
                .clk    (clk),
                .rst_n  (rst_n),
                .req    (req[gi*N_VC +: N_VC]),
                .accept (in_acc[gi]),
                .gnt    (vc_gnt[gi*N_VC +: N_VC])
            );
        end
        for (gj = 0; gj < N_PORTS; gj++) begin : g_out
            sa_rr_arb #(.WIDTH(N_PORTS)) u_out_arb (
                .clk    (clk),
                .rst_n  (rst_n),
                .req    (out_req[gj*N_PORTS +: N_PORTS]),
                .accept (out_any[gj]),
                .gnt    (out_gnt[gj*N_PORTS +: N_PORTS])
            );
        end
    endgenerate

    // Turn each input winner into a request for its target output.
    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            in_any[i]   = |vc_gnt[i*N_VC +: N_VC];
            win_port[i] = '0;
            for (int v = 0; v < N_VC; v++) begin
                if (vc_gnt[i*N_VC+v]) win_port[i] = port_of[(i*N_VC+v)*PW +: PW];
            end
        end
        for (int j = 0; j < N_PORTS; j++) begin
            for (int i = 0; i < N_PORTS; i++) begin
                out_req[j*N_PORTS+i] = in_any[i] && (int'(win_port[i]) == j);
            end
        end
    end

    // Fold output grants back to inputs and their VCs.
    always_comb begin
        in_acc = '0;
        for (int j = 0; j < N_PORTS; j++) begin
            out_any[j] = |out_gnt[j*N_PORTS +: N_PORTS];
            for (int i = 0; i < N_PORTS; i++) begin
                if (out_gnt[j*N_PORTS+i]) in_acc[i] = 1'b1;
            end
        end
        for (int s = 0; s < N_PORTS*N_VC; s++) begin
            deq[s] = vc_gnt[s] & in_acc[s/N_VC];
        end
    end
endmodule

// File: rtl/sa_credit_bank.sv
// Credit counters, one per output VC.
// Loaded with DEPTH on reset, reduced on consume, raised on return.
// avail excludes a credit already being consumed this cycle.
// Assumes: downstream never returns more credits than it was sent.
module sa_credit_bank #(
    parameter int N_SLOTS = 8,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SLOTS-1:0] consume,
    input  logic [N_SLOTS-1:0] ret,
    output logic [N_SLOTS-1:0] avail
);
    localparam int CW = $clog2(DEPTH + 1);

    genvar g;
    generate
        for (g = 0; g < N_SLOTS; g++) begin : g_slot
            logic [CW-1:0] cnt;

            // Net change: minus consumption, plus return.
            always_ff @(posedge clk) begin
                if (!rst_n) cnt <= CW'(DEPTH);
                else        cnt <= cnt - CW'(consume[g]) + CW'(ret[g]);
            end

            assign avail[g] = cnt > CW'(consume[g]);
        end
    endgenerate
endmodule

// File: rtl/sa_xbar_pipe.sv
// Switch allocation stage followed by a registered crossbar stage.
// Cycle k: requests, allocation, dequeue, capture into stage registers.
// Cycle k+1: crossbar output, VC field rewrite visible, credit consumed.
// Assumes: per-VC buffers pop on deq; DATA_W is wider than the VC field.
module sa_xbar_pipe #(
    parameter int N_PORTS = 4,
    parameter int N_VC    = 2,
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 4,
    parameter int PW      = sa_pkg::idx_w(N_PORTS),
    parameter int VW      = sa_pkg::idx_w(N_VC)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_PORTS*N_VC-1:0]        flit_valid,
    input  logic [N_PORTS*N_VC*DATA_W-1:0] flit_data,
    input  logic [N_PORTS*N_VC*PW-1:0]     out_port,
    input  logic [N_PORTS*N_VC*VW-1:0]     out_vc,
    input  logic [N_PORTS*N_VC-1:0]        out_vc_lock,
    output logic [N_PORTS*N_VC-1:0]        deq,
    output logic [N_PORTS-1:0]             out_valid,
    output logic [N_PORTS*DATA_W-1:0]      out_data,
    input  logic [N_PORTS*N_VC-1:0]        credit_in
);
    localparam int NS = N_PORTS * N_VC;

    logic [NS-1:0]              req;
    logic [NS-1:0]              vc_cons;
    logic [NS-1:0]              vc_avail;
    logic [N_PORTS-1:0]         in_acc;
    logic [N_PORTS-1:0]         out_any;
    logic [N_PORTS*N_PORTS-1:0] out_gnt;

    logic [DATA_W-1:0] mux_data [N_PORTS];
    logic [VW-1:0]     mux_vc   [N_PORTS];
    logic [PW-1:0]     gnt_idx  [N_PORTS];

    logic [DATA_W-1:0]  st_data [N_PORTS];
    logic [VW-1:0]      st_vc   [N_PORTS];
    logic [N_PORTS-1:0] sel_v;
    logic [PW-1:0]      sel_in  [N_PORTS];

    // Request only with a flit, a locked output VC and a free credit.
    always_comb begin : reqgen
        int tgt;
        for (int s = 0; s < NS; s++) begin
            tgt = int'(out_port[s*PW +: PW]) * N_VC + int'(out_vc[s*VW +: VW]);
            req[s] = flit_valid[s] && out_vc_lock[s] && (tgt < NS) && vc_avail[tgt];
        end
    end

    sa_sep_alloc #(.N_PORTS(N_PORTS), .N_VC(N_VC)) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .port_of (out_port),
        .deq     (deq),
        .in_acc  (in_acc),
        .out_gnt (out_gnt),
        .out_any (out_any)
    );

    sa_credit_bank #(.N_SLOTS(NS), .DEPTH(DEPTH)) u_credit (
        .clk     (clk),
        .rst_n   (rst_n),
        .consume (vc_cons),
        .ret     (credit_in),
        .avail   (vc_avail)
    );

    // Per-input VC multiplexer, rewriting the VC field on the way.
    always_comb begin
        for (int i = 0; i < N_PORTS; i++) begin
            mux_data[i] = '0;
            mux_vc[i]   = '0;
            for (int v = 0; v < N_VC; v++) begin
                if (deq[i*N_VC+v]) begin
                    mux_vc[i]   = out_vc[(i*N_VC+v)*VW +: VW];
                    mux_data[i] = {flit_data[(i*N_VC+v)*DATA_W + VW +: DATA_W-VW],
                                   out_vc[(i*N_VC+v)*VW +: VW]};
                end
            end
        end
    end

    // Encode each output's one-hot input grant.
    always_comb begin
        for (int j = 0; j < N_PORTS; j++) begin
            gnt_idx[j] = '0;
            for (int i = 0; i < N_PORTS; i++) begin
                if (out_gnt[j*N_PORTS+i]) gnt_idx[j] = PW'(i);
            end
        end
    end

    // Per-input data registers, loaded only on an accepted grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_PORTS; i++) begin
                st_data[i] <= '0;
                st_vc[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < N_PORTS; i++) begin
                if (in_acc[i]) begin
                    st_data[i] <= mux_data[i];
                    st_vc[i]   <= mux_vc[i];
                end
            end
        end
    end

    // Per-output select registers, refreshed every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_v <= '0;
            for (int j = 0; j < N_PORTS; j++) sel_in[j] <= '0;
        end else begin
            sel_v <= out_any;
            for (int j = 0; j < N_PORTS; j++) sel_in[j] <= gnt_idx[j];
        end
    end

    // Crossbar traversal and credit consumption.
    always_comb begin
        vc_cons   = '0;
        out_valid = sel_v;
        for (int j = 0; j < N_PORTS; j++) begin
            out_data[j*DATA_W +: DATA_W] = st_data[sel_in[j]];
            if (sel_v[j]) vc_cons[j*N_VC + int'(st_vc[sel_in[j]])] = 1'b1;
        end
    end
endmodule

// File: rtl/sa_xbar_pipe_chk.sv
// Port-level checker for sa_xbar_pipe, attached by bind below.
// Keeps its own credit tally from delivered flits and returned credits.
module sa_xbar_pipe_chk #(
    parameter int N_PORTS = 4,
    parameter int N_VC    = 2,
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 4,
    parameter int PW      = sa_pkg::idx_w(N_PORTS),
    parameter int VW      = sa_pkg::idx_w(N_VC)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [N_PORTS*N_VC-1:0]        flit_valid,
    input logic [N_PORTS*N_VC*DATA_W-1:0] flit_data,
    input logic [N_PORTS*N_VC*PW-1:0]     out_port,
    input logic [N_PORTS*N_VC*VW-1:0]     out_vc,
    input logic [N_PORTS*N_VC-1:0]        out_vc_lock,
    input logic [N_PORTS*N_VC-1:0]        deq,
    input logic [N_PORTS-1:0]             out_valid,
    input logic [N_PORTS*DATA_W-1:0]      out_data,
    input logic [N_PORTS*N_VC-1:0]        credit_in
);
    localparam int NS = N_PORTS * N_VC;
    localparam int CW = $clog2(DEPTH + 1) + 1;

    logic [NS-1:0] dlv;
    logic [CW-1:0] tally [NS];

    // Which output VCs received a flit this cycle.
    always_comb begin
        dlv = '0;
        for (int j = 0; j < N_PORTS; j++) begin
            if (out_valid[j]) dlv[j*N_VC + int'(out_data[j*DATA_W +: VW])] = 1'b1;
        end
    end

    // Credit tally observed at the ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NS; s++) tally[s] <= CW'(DEPTH);
        end else begin
            for (int s = 0; s < NS; s++) tally[s] <= tally[s] - CW'(dlv[s]) + CW'(credit_in[s]);
        end
    end

    AST_DEQ_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (deq & ~(flit_valid & out_vc_lock)) == '0); // R2

    AST_OUT_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid) == ($past(rst_n) ? $countones($past(deq)) : 0)); // R4

    genvar gi, gj;
    generate
        for (gi = 0; gi < N_PORTS; gi++) begin : g_in
            AST_ONE_DEQ_PER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(deq[gi*N_VC +: N_VC])); // R3
        end
        for (gj = 0; gj < N_PORTS; gj++) begin : g_out
            AST_NO_CREDIT_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid[gj] |-> (tally[gj*N_VC + int'(out_data[gj*DATA_W +: VW])] != '0)); // R8
        end
    endgenerate
endmodule

bind sa_xbar_pipe sa_xbar_pipe_chk #(
    .N_PORTS(N_PORTS), .N_VC(N_VC), .DATA_W(DATA_W), .DEPTH(DEPTH), .PW(PW), .VW(VW)
) u_chk (.*);

// File: tb/sim_sa_xbar_pipe.sv
// Scoreboard bench: send() pushes expected flits per source, the monitor
// pops and compares every flit that leaves an output.
module sim_sa_xbar_pipe;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int V  = 2;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int NS = N * V;
    localparam int PW = 2;
    localparam int VW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [NS-1:0]    flit_valid;
    logic [NS*DW-1:0] flit_data;
    logic [NS*PW-1:0] out_port;
    logic [NS*VW-1:0] out_vc;
    logic [NS-1:0]    out_vc_lock;
    logic [NS-1:0]    deq;
    logic [N-1:0]     out_valid;
    logic [N*DW-1:0]  out_data;
    logic [NS-1:0]    credit_in;

    sa_xbar_pipe #(.N_PORTS(N), .N_VC(V), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_data(flit_data),
        .out_port(out_port), .out_vc(out_vc), .out_vc_lock(out_vc_lock), .deq(deq),
        .out_valid(out_valid), .out_data(out_data), .credit_in(credit_in)
    );

    typedef struct packed {
        logic [PW-1:0] port;
        logic [VW-1:0] vc;
        logic [DW-1:0] data;
    } flit_t;

    flit_t fifo  [NS][$];
    flit_t exp_q [NS][$];
    int glog[$];
    int olog[N][$];
    int bcnt[NS];
    int checks = 0;
    int fails = 0;
    int total_out = 0;
    int seq = 0;
    bit auto_ret = 1'b1;
    logic [NS-1:0] lock_en = '1;
    logic [NS-1:0] cred_hold = '0;
    logic [NS-1:0] auto_next = '0;
    logic [NS-1:0] deq_prev = '0;
    logic [NS-1:0] deq_s;

    task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // Driver: queue flits into a source buffer and the scoreboard.
    task automatic send(input int src, input int port, input int vc, input int n);
        for (int k = 0; k < n; k++) begin
            flit_t f;
            flit_t e;
            f.port = PW'(port);
            f.vc   = VW'(vc);
            f.data = {4'(src), 11'(seq), VW'(~vc)};
            seq++;
            e = f;
            e.data[VW-1:0] = VW'(vc);
            fifo[src].push_back(f);
            exp_q[src].push_back(e);
        end
    endtask

    task automatic drive();
        for (int s = 0; s < NS; s++) begin
            if (fifo[s].size() > 0) begin
                flit_valid[s]            = 1'b1;
                flit_data[s*DW +: DW]    = fifo[s][0].data;
                out_port[s*PW +: PW]     = fifo[s][0].port;
                out_vc[s*VW +: VW]       = fifo[s][0].vc;
            end else begin
                flit_valid[s]            = 1'b0;
                flit_data[s*DW +: DW]    = '0;
                out_port[s*PW +: PW]     = '0;
                out_vc[s*VW +: VW]       = '0;
            end
            out_vc_lock[s] = lock_en[s];
        end
        credit_in = cred_hold | auto_next;
    endtask

    // Monitor: compare outputs with the dequeues of the previous cycle.
    task automatic monitor(input logic [NS-1:0] dq);
        logic [NS-1:0] nxt;
        int nout;
        bit ok1;
        nxt  = '0;
        nout = 0;
        if (dq != '0) begin
            ok1 = 1'b1;
            for (int i = 0; i < N; i++) if (!$onehot0(dq[i*V +: V])) ok1 = 1'b0;
            check(ok1, "R3", "one deq per input", int'(dq), 0);
        end
        for (int j = 0; j < N; j++) begin
            if (out_valid[j]) begin
                logic [DW-1:0] d;
                int src;
                int slot;
                flit_t e;
                d    = out_data[j*DW +: DW];
                src  = int'(d[15:12]);
                slot = j*V + int'(d[VW-1:0]);
                nout++;
                total_out++;
                glog.push_back(src);
                olog[j].push_back(src);
                check(src < NS && deq_prev[src], "R4", "flit granted one cycle earlier", src, 1);
                check(bcnt[slot] > 0, "R8", "credit available at send", bcnt[slot], 1);
                bcnt[slot]--;
                if (src >= NS || exp_q[src].size() == 0) begin
                    check(1'b0, "R4", "unexpected flit source", src, -1);
                end else begin
                    e = exp_q[src].pop_front();
                    check(int'(e.port) == j, "R4", "output port", j, int'(e.port));
                    check(d == e.data, "R5", "data with rewritten VC field", int'(d), int'(e.data));
                end
                if (auto_ret) nxt[slot] = 1'b1;
            end
        end
        if (nout > 0 || deq_prev != '0)
            check(nout == $countones(deq_prev), "R4", "outputs match prior dequeues", nout, $countones(deq_prev));
        for (int s = 0; s < NS; s++) bcnt[s] += int'(credit_in[s]);
        auto_next = nxt;
    endtask

    // Buffer model and monitor loop.
    initial begin
        for (int s = 0; s < NS; s++) bcnt[s] = DEPTH;
        drive();
        forever begin
            @(negedge clk);
            deq_s = deq;
            if (rst_n) begin
                monitor(deq_s);
                deq_prev = deq_s;
            end else begin
                deq_prev = '0;
            end
            @(posedge clk);
            #1;
            if (rst_n) begin
                for (int s = 0; s < NS; s++) if (deq_s[s] && fifo[s].size() > 0) void'(fifo[s].pop_front());
            end
            drive();
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "WDG", "run timed out", 0, 1);
        finish_run();
    end

    // Directed sequence.
    initial begin
        int base;
        bit okseq;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        wait_cycles(1);
        check(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(deq == '0, "R1", "deq after reset", int'(deq), 0);

        // R2: a VC without a lock is ignored.
        lock_en = '0;
        base = total_out;
        send(0, 1, 0, 2);
        wait_cycles(8);
        check(total_out == base, "R2", "no delivery without lock", total_out - base, 0);
        check(deq == '0, "R2", "no deq without lock", int'(deq), 0);
        lock_en = '1;
        wait_cycles(10);
        check(total_out - base == 2, "R2", "delivery after lock", total_out - base, 2);

        // R7: inputs 0 and 1 compete for output 2.
        for (int j = 0; j < N; j++) olog[j].delete();
        send(0, 2, 0, 3);
        send(2, 2, 1, 3);
        wait_cycles(15);
        okseq = (olog[2].size() == 6);
        for (int k = 0; k < olog[2].size(); k++) if (olog[2][k] != ((k % 2 == 0) ? 0 : 2)) okseq = 1'b0;
        check(okseq, "R7", "output round-robin order", olog[2].size() > 1 ? olog[2][1] : -1, 2);

        // R6: VCs 0 and 1 of input 3 compete inside the input.
        glog.delete();
        send(6, 0, 0, 3);
        send(7, 3, 0, 3);
        wait_cycles(15);
        okseq = (glog.size() == 6);
        for (int k = 0; k < glog.size(); k++) if (glog[k] != ((k % 2 == 0) ? 6 : 7)) okseq = 1'b0;
        check(okseq, "R6", "input round-robin order", glog.size() > 1 ? glog[1] : -1, 7);

        // R8 and R1: exactly DEPTH flits without returns, then two more.
        auto_ret = 1'b0;
        wait_cycles(2);
        base = total_out;
        send(4, 1, 1, 6);
        wait_cycles(20);
        check(total_out - base == DEPTH, "R8", "stall at zero credit (R1 depth)", total_out - base, DEPTH);
        check(deq == '0, "R8", "no request at zero credit", int'(deq), 0);
        cred_hold[3] = 1'b1;
        wait_cycles(2);
        cred_hold[3] = 1'b0;
        wait_cycles(15);
        check(total_out - base == 6, "R8", "sent after two returns", total_out - base, 6);

        // R9: returns overlapping consumption on output 0 VC 1.
        base = total_out;
        send(5, 0, 1, 10);
        cred_hold[1] = 1'b1;
        wait_cycles(3);
        cred_hold[1] = 1'b0;
        wait_cycles(40);
        check(total_out - base == DEPTH + 3, "R9", "depth plus returns delivered", total_out - base, DEPTH + 3);
        check(exp_q[5].size() == 3, "R9", "flits left waiting", exp_q[5].size(), 3);
        check(exp_q[4].size() == 0, "R4", "no flit lost", exp_q[4].size(), 0);

        finish_run();
    end
endmodule